// File: doc/BRIEF.md
# Golomb Run-Length Test Pattern Expander

This block sits between a one-bit tester channel and the scan input of a core under test. The tester sends a compressed stream of Golomb codewords. Each codeword describes one run of zeros that ends in a single one inside a difference-vector stream. The block expands each codeword back into that run, one decoded bit per cycle, and marks each decoded bit with a valid strobe. A cyclical register as long as the scan chain turns the difference stream back into test patterns. Each decoded bit is combined by exclusive-or with the bit leaving that register, and the result is both the scan-in bit and the new register entry.

The group size `GROUP` (m) is a power of two, at least 2. Let TW be log2(m). A run of length L is coded as floor(L/m) one-bits, then a zero separator, then the remainder L mod m in TW bits. The tester presents a bit on `enc_bit`, and that bit is taken on every rising clock edge at which `enc_en` is high. While the block is expanding a run, `enc_en` stays low and the tester holds its bit.

Top module: `gdec_top`

## Requirements
- R1: A synchronous active-high reset puts the block in the prefix-accepting state, with `enc_en`=1 and `diff_valid`=0. It also clears the cyclical register to all zeros, so the first CHAIN_LEN scan bits after reset equal the decoded difference bits.
- R2: `enc_en` is high only in cycles that take a prefix bit, the separator or a tail bit. A codeword for run L therefore holds `enc_en` high for floor(L/m)+1+TW cycles.
- R3: A prefix bit of value 1 is followed by exactly m cycles with `diff_valid`=1 and `diff_bit`=0, during which `enc_en` is 0. The block then accepts the next bit.
- R4: A prefix bit of value 0 is the separator. The next TW accepted bits form the remainder, most significant bit first.
- R5: A remainder r produces r+1 consecutive valid cycles: r zeros, then a single `diff_bit`=1 that ends the run. After that the block accepts a prefix bit again. Tail output therefore lasts between 1 and m cycles.
- R6: `diff_valid` and `enc_en` are never high in the same cycle.
- R7: `scan_valid` equals `diff_valid`. On the k-th valid cycle, `scan_bit` = `diff_bit` XOR the scan bit from valid cycle k-CHAIN_LEN, or 0 if there is none. The cyclical register holds its contents in cycles without a valid output.
- R8: A codeword for run L takes exactly floor(L/m)*(m+1) + 1 + TW + (L mod m) + 1 cycles. Back-to-back codewords decode into the concatenated runs with no gap or lost bit.
- R9: A reset asserted in the middle of a run expansion abandons it. Decoding of a fresh stream then starts from a cleared state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_bit | input | 1 | Compressed stream bit from the tester |
| enc_en | output | 1 | High when `enc_bit` is taken at the next rising edge |
| diff_bit | output | 1 | Decoded difference-vector bit |
| diff_valid | output | 1 | `diff_bit` is meaningful this cycle |
| scan_bit | output | 1 | Rebuilt pattern bit for the scan chain |
| scan_valid | output | 1 | `scan_bit` is meaningful this cycle |

## Verification
Two things can fall in the same cycle. The terminating one of a run can be produced while the cyclical register's oldest bit, a pattern bit from one chain length earlier, is also leaving, so the register feedback and the run boundary meet. The stimulus chains short runs (L=0, L=1) and runs that straddle the chain length, so ones from the tail stage land on register positions that already hold ones. Each scan bit is judged against a bench history of expected pattern bits. A second collision is a reset landing inside a prefix expansion. That case is judged by checking the idle handshake, and then checking that the next stream's first chain length of scan bits equals its difference bits.

// File: rtl/gdec_pkg.sv
package gdec_pkg;

  typedef enum logic [1:0] {
    ST_PFX  = 2'd0,   // take a prefix bit or the separator
    ST_ZRUN = 2'd1,   // expand one prefix one into GROUP zeros
    ST_TAIL = 2'd2,   // shift in remainder bits
    ST_EMIT = 2'd3    // emit remainder zeros then the closing one
  } gdec_state_e;

  // A counter has reached its limit.
  function automatic logic count_done(input int unsigned cnt, input int unsigned limit);
    return cnt == limit;
  endfunction

  // Bit produced in the emit phase: one only at the last position.
  function automatic logic emit_value(input int unsigned pos, input int unsigned rem);
    return pos == rem;
  endfunction

  // Pattern bit from difference bit and the bit leaving the ring.
  function automatic logic rebuild_bit(input logic diff, input logic oldest);
    return diff ^ oldest;
  endfunction

endpackage

// File: rtl/gdec_ctrl.sv
module gdec_ctrl
  import gdec_pkg::*;
#(
  parameter int unsigned GROUP = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic enc_bit,
  output logic enc_en,
  output logic dbit,
  output logic dvalid,
  output logic at_prefix
);
  // GROUP must be a power of two, at least 2.
  localparam int unsigned TW = $clog2(GROUP);
  localparam int unsigned LAST_ZERO = GROUP - 1;
  localparam int unsigned LAST_TAIL = TW - 1;

  gdec_state_e      state_q;
  logic [TW-1:0]    cnt_q;   // shared run / tail-bit counter
  logic [TW-1:0]    rem_q;
  logic [TW-1:0]    rem_shift;

  assign rem_shift = TW'({rem_q, enc_bit});

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_PFX;
      cnt_q   <= '0;
      rem_q   <= '0;
    end else begin
      unique case (state_q)
        ST_PFX: begin
          cnt_q <= '0;
          if (enc_bit) begin
            state_q <= ST_ZRUN;
          end else begin
            state_q <= ST_TAIL;
            rem_q   <= '0;
          end
        end
        ST_ZRUN: begin
          if (count_done(32'(cnt_q), LAST_ZERO)) begin
            state_q <= ST_PFX;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_TAIL: begin
          rem_q <= rem_shift;
          if (count_done(32'(cnt_q), LAST_TAIL)) begin
            state_q <= ST_EMIT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_EMIT: begin
          if (count_done(32'(cnt_q), 32'(rem_q))) begin
            state_q <= ST_PFX;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_PFX;
      endcase
    end
  end

  assign at_prefix = (state_q == ST_PFX);
  assign enc_en    = (state_q == ST_PFX) || (state_q == ST_TAIL);
  assign dvalid    = (state_q == ST_ZRUN) || (state_q == ST_EMIT);
  assign dbit      = (state_q == ST_EMIT) && emit_value(32'(cnt_q), 32'(rem_q));

endmodule

// File: rtl/gdec_ring.sv
module gdec_ring
  import gdec_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic dvalid,
  input  logic dbit,
  output logic pat_bit,
  output logic oldest
);
  // CHAIN_LEN must be at least 2.
  logic [CHAIN_LEN-1:0] ring_q;

  assign oldest  = ring_q[CHAIN_LEN-1];
  assign pat_bit = rebuild_bit(dbit, oldest);

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_q <= '0;
    end else if (dvalid) begin
      ring_q <= {ring_q[CHAIN_LEN-2:0], pat_bit};
    end
  end

endmodule

// File: rtl/gdec_top.sv
module gdec_top #(
  parameter int unsigned GROUP     = 4,
  parameter int unsigned CHAIN_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic enc_bit,
  output logic enc_en,
  output logic diff_bit,
  output logic diff_valid,
  output logic scan_bit,
  output logic scan_valid
);
  logic ctrl_at_prefix;
  logic pfx_one_taken;   // a prefix one is accepted this cycle
  logic csr_oldest;      // bit leaving the cyclical register

  gdec_ctrl #(.GROUP(GROUP)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .enc_bit   (enc_bit),
    .enc_en    (enc_en),
    .dbit      (diff_bit),
    .dvalid    (diff_valid),
    .at_prefix (ctrl_at_prefix)
  );

  gdec_ring #(.CHAIN_LEN(CHAIN_LEN)) u_ring (
    .clk     (clk),
    .rst     (rst),
    .dvalid  (diff_valid),
    .dbit    (diff_bit),
    .pat_bit (scan_bit),
    .oldest  (csr_oldest)
  );

  assign pfx_one_taken = ctrl_at_prefix && enc_bit;
  assign scan_valid    = diff_valid;

endmodule

// File: rtl/gdec_checks.sv
module gdec_checks #(
  parameter int unsigned GROUP = 4
) (
  input logic clk,
  input logic rst,
  input logic enc_en,
  input logic diff_valid,
  input logic diff_bit,
  input logic pfx_one_taken,
  input logic csr_oldest
);
  logic [15:0] vrun_q;   // consecutive valid cycles so far

  always_ff @(posedge clk) begin
    if (rst)             vrun_q <= '0;
    else if (diff_valid) vrun_q <= vrun_q + 1'b1;
    else                 vrun_q <= '0;
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (enc_en && !diff_valid));

  a_r2_en_after_one: assert property (@(posedge clk) disable iff (rst)
    pfx_one_taken |=> !enc_en);

  a_r3_one_starts_zero: assert property (@(posedge clk) disable iff (rst)
    pfx_one_taken |=> (diff_valid && !diff_bit));

  a_r5_one_returns: assert property (@(posedge clk) disable iff (rst)
    (diff_valid && diff_bit) |=> (enc_en && !diff_valid));

  a_r5_run_bound: assert property (@(posedge clk) disable iff (rst)
    diff_valid |-> (32'(vrun_q) < GROUP));

  a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(enc_en && diff_valid));

  a_r7_csr_hold: assert property (@(posedge clk) disable iff (rst)
    !diff_valid |=> $stable(csr_oldest));

endmodule

bind gdec_top gdec_checks #(.GROUP(GROUP)) u_checks (
  .clk           (clk),
  .rst           (rst),
  .enc_en        (enc_en),
  .diff_valid    (diff_valid),
  .diff_bit      (diff_bit),
  .pfx_one_taken (pfx_one_taken),
  .csr_oldest    (csr_oldest)
);

// File: tb/gdec_top_bench.sv
`timescale 1ns/1ps
module gdec_top_bench;
  localparam int GROUP = 4;
  localparam int CHAIN = 8;
  localparam int TW    = $clog2(GROUP);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enc_bit = 1'b0;
  logic enc_en, diff_bit, diff_valid, scan_bit, scan_valid;

  int checks = 0;
  int errors = 0;
  int runs_q[$];
  bit stream_q[$];
  bit diff_q[$];
  bit scan_q[$];

  always #2.5 clk = ~clk;

  gdec_top #(.GROUP(GROUP), .CHAIN_LEN(CHAIN)) u_gdec_top (
    .clk(clk), .rst(rst), .enc_bit(enc_bit), .enc_en(enc_en),
    .diff_bit(diff_bit), .diff_valid(diff_valid),
    .scan_bit(scan_bit), .scan_valid(scan_valid)
  );

  function automatic int cw_cycles(input int len);
    return (len / GROUP) * (GROUP + 1) + 1 + TW + (len % GROUP) + 1;
  endfunction

  function automatic int cw_en(input int len);
    return (len / GROUP) + 1 + TW;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    enc_bit = 1'b0;
    repeat (2) @(negedge clk);
    chk(enc_en == 1'b1 && diff_valid == 1'b0, "R1 reset state en/valid",
        {enc_en, diff_valid}, 2);
    rst = 1'b0;
  endtask

  task automatic run_seq(input string tag, input int abort_after);
    int exp_cyc = 0;
    int exp_en = 0;
    int cyc = 0;
    int en_n = 0;
    int ovl = 0;
    int outs = 0;
    int idx = 0;
    int limit;
    bit e_s;
    stream_q.delete(); diff_q.delete(); scan_q.delete();
    foreach (runs_q[i]) begin
      int len = runs_q[i];
      int q = len / GROUP;
      int r = len % GROUP;
      repeat (q) stream_q.push_back(1'b1);
      stream_q.push_back(1'b0);
      for (int b = TW - 1; b >= 0; b--) stream_q.push_back(bit'((r >> b) & 1));
      repeat (len) diff_q.push_back(1'b0);
      diff_q.push_back(1'b1);
      exp_cyc += cw_cycles(len);
      exp_en  += cw_en(len);
    end
    limit = exp_cyc + 50;
    while (outs < diff_q.size() && cyc < limit && !(abort_after > 0 && cyc >= abort_after)) begin
      cyc++;
      if (diff_valid) begin
        e_s = diff_q[outs] ^ ((outs >= CHAIN) ? scan_q[outs - CHAIN] : 1'b0);
        scan_q.push_back(e_s);
        chk(diff_bit == diff_q[outs], {tag, " R3 R4 R5 decoded bit"}, diff_bit, diff_q[outs]);
        chk(scan_bit == e_s && scan_valid, {tag, " R7 pattern bit"}, scan_bit, e_s);
        outs++;
      end
      if (enc_en) en_n++;
      if (enc_en && diff_valid) ovl++;
      if (enc_en) begin
        enc_bit = (idx < stream_q.size()) ? stream_q[idx] : 1'b0;
        idx++;
      end
      @(negedge clk);
    end
    if (abort_after == 0) begin
      chk(outs == diff_q.size(), {tag, " R8 all bits emitted"}, outs, diff_q.size());
      chk(cyc == exp_cyc, {tag, " R8 cycle total"}, cyc, exp_cyc);
      chk(en_n == exp_en, {tag, " R2 enable cycles"}, en_n, exp_en);
      chk(ovl == 0, {tag, " R6 no overlap"}, ovl, 0);
    end
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    @(negedge clk);
    do_reset();

    // Directed: boundary runs, remainder order, chain wrap.
    runs_q = '{0, GROUP - 1, GROUP, 2 * GROUP + 1, 1, 2, 0, 3 * GROUP + 2};
    run_seq("dir_mix", 0);
    do_reset();

    // Directed: all-ones difference stream and maximal tails (R5 bounds).
    runs_q = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, GROUP - 1, GROUP - 1, GROUP - 1};
    run_seq("dir_tail", 0);
    do_reset();

    // Random runs.
    for (int s = 0; s < 6; s++) begin
      runs_q.delete();
      for (int k = 0; k < 14; k++) runs_q.push_back(int'($urandom_range(0, 4 * GROUP + 1)));
      run_seq("rand", 0);
      do_reset();
    end

    // R9: abandon a long prefix expansion mid-run, then start fresh.
    runs_q = '{5 * GROUP + 1};
    run_seq("R9 abort", 4);
    do_reset();
    runs_q = '{1, 0, GROUP + 3, 2};
    run_seq("R9 R1 after abort", 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule